// File: doc/BRIEF.md
# Multichannel DAC Code Register Bank with Clear

This block keeps the digital code state for a bank of DAC channels. Each channel owns two register pairs, A and B, and each pair is a buffer register and an active register. The active register drives the channel's output code. A channel set for asynchronous update copies a write into the buffer and the active register together. A channel set for synchronous update accepts a write into its buffer only. A single load strobe then moves the buffer into the active register, on the same edge, for every synchronous channel.

Each channel has its own configuration inputs: range (unipolar or bipolar), differential pairing, toggle mode and update mode. In toggle mode a per-channel select input picks pair A or pair B as the output. Outside toggle mode a channel always shows pair A.

An active-low clear input overrides every other input. While clear is low, each channel shows a clear code. The clear code depends on that channel's range and differential setting. At each rising edge during clear, all four registers of every channel are loaded with that code. The serial front end and the analog outputs sit outside this block.

Top module: `dac_code_bank`

## Requirements
- R1: While `rstN` is low, every register in every channel is forced to 0x0000. With `clrN` high after reset, every channel code reads 0x0000.
- R2: While `clrN` is low, each channel's output equals its clear code in the same cycle. This holds in both synchronous and asynchronous update modes.
- R3: The clear code is 0x0000 for a unipolar (`cfgBipolar`=0), non-differential (`cfgDiff`=0) channel. In every other combination it is midscale, 0x8000.
- R4: A rising edge with `clrN` low loads the clear code into the buffer and active registers of both pair A and pair B. After release, the channel shows the clear code for either toggle select and after a load strobe.
- R5: While `clrN` is low, register writes and load strobes have no effect. Once clear is released, a channel shows its clear code, not the data written during clear.
- R6: On an asynchronous channel (`cfgSync`=0), a write with `wrSel`=0 reaches the output code on the cycle after the write edge.
- R7: On a synchronous channel (`cfgSync`=1), a write changes only the buffer. The output code does not change until a load strobe.
- R8: A `loadStb` pulse copies buffer to active, for both pairs, in every synchronous channel on the same edge. Asynchronous channels are not affected.
- R9: With `cfgToggle`=1, `togSel`=1 outputs pair B and `togSel`=0 outputs pair A. A write with `wrSel`=1 targets pair B. With `cfgToggle`=0 the output is always pair A.
- R10: When a write and a load strobe hit a synchronous channel on the same edge, the active register takes the buffer value from before that edge, and the buffer takes the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clrN | input | 1 | Clear request, active low |
| wrEn | input | 1 | Register write enable |
| wrCh | input | $clog2(NUM_CH) | Channel addressed by the write |
| wrSel | input | 1 | Write target: 0 = pair A, 1 = pair B |
| wrData | input | CODE_W | Write data |
| loadStb | input | 1 | One-cycle load strobe for synchronous channels |
| cfgBipolar | input | NUM_CH | Per-channel range: 1 = bipolar |
| cfgDiff | input | NUM_CH | Per-channel differential pairing |
| cfgToggle | input | NUM_CH | Per-channel toggle mode |
| cfgSync | input | NUM_CH | Per-channel update mode: 1 = synchronous |
| togSel | input | NUM_CH | Per-channel toggle select: 1 = pair B |
| chCode | output | NUM_CH*CODE_W | Active codes; channel c occupies bits [c*CODE_W +: CODE_W] |

## Verification
The bound checker watches the following properties on every clock edge:
- During clear, each output matches the clear code its configuration calls for.
- The cleared value survives the release of clear.
- A write to an asynchronous channel shows on the next cycle.
- A synchronous channel's output stays still until a load strobe.

Other behaviours need directed scenarios in the bench:
- Writes and loads during clear are discarded.
- Both toggle pairs are cleared.
- A load that lands on the same edge as a write sees the old buffer.

A bench model, driven by seeded random traffic, then checks every channel on every cycle.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

  // Per-channel strobes passed from the control to the datapath
  typedef struct packed {
    logic bufWrA;
    logic bufWrB;
    logic actWrA;
    logic actWrB;
    logic load;
    logic clr;
  } chStrobe_t;

  // Midscale clear is used unless the channel is unipolar and single-ended
  function automatic logic useMidClear(input logic bipolar, input logic diff);
    return bipolar | diff;
  endfunction

endpackage

// File: rtl/dac_bank_ctrl.sv
module dac_bank_ctrl
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int AW = $clog2(NUM_CH)
) (
  input  logic              clrN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrCh,
  input  logic              wrSel,
  input  logic              loadStb,
  input  logic [NUM_CH-1:0] cfgSync,
  output chStrobe_t         strb [NUM_CH]
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = clrN && wrEn && (wrCh == AW'(c));
    always_comb begin
      strb[c].bufWrA = hit && !wrSel;
      strb[c].bufWrB = hit && wrSel;
      strb[c].actWrA = hit && !wrSel && !cfgSync[c];
      strb[c].actWrB = hit && wrSel && !cfgSync[c];
      strb[c].load   = clrN && loadStb && cfgSync[c];
      strb[c].clr    = !clrN;
    end
  end

endmodule

// File: rtl/dac_bank_datapath.sv
module dac_bank_datapath
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  chStrobe_t                strb [NUM_CH],
  input  logic [CODE_W-1:0]        wrData,
  input  logic [NUM_CH-1:0]        cfgBipolar,
  input  logic [NUM_CH-1:0]        cfgDiff,
  input  logic [NUM_CH-1:0]        cfgToggle,
  input  logic [NUM_CH-1:0]        togSel,
  output logic [NUM_CH*CODE_W-1:0] chCode
);

  localparam logic [CODE_W-1:0] ZERO_CODE = '0;
  localparam logic [CODE_W-1:0] MID_CODE  = CODE_W'(1) << (CODE_W - 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0] bufA, bufB, actA, actB, clrCode;

    assign clrCode = useMidClear(cfgBipolar[c], cfgDiff[c]) ? MID_CODE : ZERO_CODE;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufA <= '0;
        bufB <= '0;
        actA <= '0;
        actB <= '0;
      end else if (strb[c].clr) begin
        bufA <= clrCode;
        bufB <= clrCode;
        actA <= clrCode;
        actB <= clrCode;
      end else begin
        if (strb[c].bufWrA) bufA <= wrData;
        if (strb[c].bufWrB) bufB <= wrData;
        if (strb[c].actWrA)    actA <= wrData;
        else if (strb[c].load) actA <= bufA;
        if (strb[c].actWrB)    actB <= wrData;
        else if (strb[c].load) actB <= bufB;
      end
    end

    always_comb begin
      if (strb[c].clr)
        chCode[c*CODE_W +: CODE_W] = clrCode;
      else if (cfgToggle[c] && togSel[c])
        chCode[c*CODE_W +: CODE_W] = actB;
      else
        chCode[c*CODE_W +: CODE_W] = actA;
    end
  end

endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 16,
  localparam int AW = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clrN,
  input  logic                     wrEn,
  input  logic [AW-1:0]            wrCh,
  input  logic                     wrSel,
  input  logic [CODE_W-1:0]        wrData,
  input  logic                     loadStb,
  input  logic [NUM_CH-1:0]        cfgBipolar,
  input  logic [NUM_CH-1:0]        cfgDiff,
  input  logic [NUM_CH-1:0]        cfgToggle,
  input  logic [NUM_CH-1:0]        cfgSync,
  input  logic [NUM_CH-1:0]        togSel,
  output logic [NUM_CH*CODE_W-1:0] chCode
);

  chStrobe_t strb [NUM_CH];

  dac_bank_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clrN(clrN), .wrEn(wrEn), .wrCh(wrCh), .wrSel(wrSel),
    .loadStb(loadStb), .cfgSync(cfgSync), .strb(strb)
  );

  dac_bank_datapath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .cfgBipolar(cfgBipolar), .cfgDiff(cfgDiff), .cfgToggle(cfgToggle),
    .togSel(togSel), .chCode(chCode)
  );

endmodule

// File: rtl/dac_code_bank_chk.sv
module dac_code_bank_chk #(
  parameter int NUM_CH = 16,
  parameter int CODE_W = 16,
  localparam int AW = $clog2(NUM_CH)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     clrN,
  input logic                     wrEn,
  input logic [AW-1:0]            wrCh,
  input logic                     wrSel,
  input logic [CODE_W-1:0]        wrData,
  input logic                     loadStb,
  input logic [NUM_CH-1:0]        cfgBipolar,
  input logic [NUM_CH-1:0]        cfgDiff,
  input logic [NUM_CH-1:0]        cfgToggle,
  input logic [NUM_CH-1:0]        cfgSync,
  input logic [NUM_CH-1:0]        togSel,
  input logic [NUM_CH*CODE_W-1:0] chCode
);

  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_CLEAR_CODE: assert property (@(posedge clk) disable iff (!rstN)
      !clrN |-> chCode[c*CODE_W +: CODE_W] == ((cfgBipolar[c] || cfgDiff[c]) ? MID : '0)); // R3

    AST_CLEAR_RETAINED: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(clrN) && $stable(cfgBipolar[c]) && $stable(cfgDiff[c]))
        |-> chCode[c*CODE_W +: CODE_W] == $past(chCode[c*CODE_W +: CODE_W])); // R4

    AST_ASYNC_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      ($past(clrN && wrEn && wrCh == AW'(c) && !wrSel && !cfgSync[c]) && clrN && !cfgToggle[c])
        |-> chCode[c*CODE_W +: CODE_W] == $past(wrData)); // R6

    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      ($past(clrN && !loadStb && cfgSync[c]) && clrN
         && $stable(cfgToggle[c]) && $stable(togSel[c]))
        |-> $stable(chCode[c*CODE_W +: CODE_W])); // R7
  end

endmodule

bind dac_code_bank dac_code_bank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_chk (
  .clk(clk), .rstN(rstN), .clrN(clrN), .wrEn(wrEn), .wrCh(wrCh), .wrSel(wrSel),
  .wrData(wrData), .loadStb(loadStb), .cfgBipolar(cfgBipolar), .cfgDiff(cfgDiff),
  .cfgToggle(cfgToggle), .cfgSync(cfgSync), .togSel(togSel), .chCode(chCode)
);

// File: tb/test_dac_code_bank.sv
`timescale 1ns/1ps
module test_dac_code_bank;
  localparam int NCH = 16;
  localparam int CW  = 16;
  localparam int AW  = $clog2(NCH);
  localparam logic [CW-1:0] MID = 16'h8000;

  logic clk = 1'b0;
  logic rstN = 1'b0, clrN = 1'b1, wrEn = 1'b0, wrSel = 1'b0, loadStb = 1'b0;
  logic [AW-1:0] wrCh = '0;
  logic [CW-1:0] wrData = '0;
  logic [NCH-1:0] bip = '0, dif = '0, tog = '0, syn = '0, tsel = '0;
  logic [NCH*CW-1:0] chCode;

  logic [CW-1:0] mBufA [NCH], mBufB [NCH], mActA [NCH], mActB [NCH];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_code_bank #(.NUM_CH(NCH), .CODE_W(CW)) i_dac_code_bank (
    .clk(clk), .rstN(rstN), .clrN(clrN), .wrEn(wrEn), .wrCh(wrCh), .wrSel(wrSel),
    .wrData(wrData), .loadStb(loadStb), .cfgBipolar(bip), .cfgDiff(dif),
    .cfgToggle(tog), .cfgSync(syn), .togSel(tsel), .chCode(chCode)
  );

  function automatic logic [CW-1:0] clrCodeOf(int c);
    return (bip[c] || dif[c]) ? MID : '0;
  endfunction

  function automatic logic [CW-1:0] expOut(int c);
    if (!clrN) return clrCodeOf(c);
    if (tog[c] && tsel[c]) return mActB[c];
    return mActA[c];
  endfunction

  task automatic modelReset();
    for (int c = 0; c < NCH; c++) begin
      mBufA[c] = '0; mBufB[c] = '0; mActA[c] = '0; mActB[c] = '0;
    end
  endtask

  task automatic modelStep();
    for (int c = 0; c < NCH; c++) begin
      if (!clrN) begin
        mBufA[c] = clrCodeOf(c); mBufB[c] = clrCodeOf(c);
        mActA[c] = clrCodeOf(c); mActB[c] = clrCodeOf(c);
      end else begin
        logic [CW-1:0] oA, oB;
        oA = mBufA[c]; oB = mBufB[c];
        if (wrEn && wrCh == AW'(c)) begin
          if (wrSel) mBufB[c] = wrData; else mBufA[c] = wrData;
          if (!syn[c]) begin
            if (wrSel) mActB[c] = wrData; else mActA[c] = wrData;
          end
        end
        if (loadStb && syn[c]) begin
          mActA[c] = oA; mActB[c] = oB;
        end
      end
    end
  endtask

  task automatic check(string tag, int c, logic [CW-1:0] exp);
    logic [CW-1:0] act;
    act = chCode[c*CW +: CW];
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s ch%0d actual=%h expected=%h", tag, c, act, exp);
    end
  endtask

  task automatic checkAll();
    for (int c = 0; c < NCH; c++) begin
      string tag;
      if (!clrN) tag = "R2";
      else if (tog[c] && tsel[c]) tag = "R9";
      else if (syn[c]) tag = "R7";
      else tag = "R6";
      check(tag, c, expOut(c));
    end
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; loadStb = 1'b0;
    #1;
  endtask

  task automatic wr(int ch, logic sel, logic [CW-1:0] d, logic ld);
    wrEn = 1'b1; wrCh = AW'(ch); wrSel = sel; wrData = d; loadStb = ld;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    for (int c = 0; c < NCH; c++) check("R1", c, 16'h0000);

    // R3 clear code table for the four range/differential combinations
    bip[1:0] = 2'b00; dif[1:0] = 2'b10; bip[3:2] = 2'b11; dif[3:2] = 2'b10;
    clrN = 1'b0; #1;
    check("R3", 0, 16'h0000); check("R3", 1, 16'h8000);
    check("R3", 2, 16'h8000); check("R3", 3, 16'h8000);
    tick();
    clrN = 1'b1; tick();
    check("R4", 1, 16'h8000); check("R4", 0, 16'h0000);

    // R6 asynchronous write
    wr(5, 1'b0, 16'h1234, 1'b0);
    check("R6", 5, 16'h1234);

    // R7, R8, R10 synchronous channel
    syn[6] = 1'b1; tick();
    wr(6, 1'b0, 16'hABCD, 1'b0);
    check("R7", 6, 16'h0000);
    loadStb = 1'b1; tick();
    check("R8", 6, 16'hABCD); check("R8", 5, 16'h1234);
    wr(6, 1'b0, 16'h2222, 1'b0);
    wr(6, 1'b0, 16'h1111, 1'b1);
    check("R10", 6, 16'h2222);
    loadStb = 1'b1; tick();
    check("R10", 6, 16'h1111);

    // R9 toggle pairs
    tog[7] = 1'b1;
    wr(7, 1'b0, 16'h0101, 1'b0);
    wr(7, 1'b1, 16'h0202, 1'b0);
    tsel[7] = 1'b0; #1; check("R9", 7, 16'h0101);
    tsel[7] = 1'b1; #1; check("R9", 7, 16'h0202);
    tog[7] = 1'b0; #1; check("R9", 7, 16'h0101);
    tog[7] = 1'b1;

    // R4, R5 clear with writes and loads present
    bip[7] = 1'b1; clrN = 1'b0;
    wr(7, 1'b0, 16'h5555, 1'b1);
    check("R2", 7, 16'h8000);
    wr(6, 1'b0, 16'h7777, 1'b1);
    clrN = 1'b1; tsel[7] = 1'b0; #1;
    check("R5", 7, 16'h8000); check("R5", 6, 16'h0000);
    tsel[7] = 1'b1; #1; check("R4", 7, 16'h8000);
    loadStb = 1'b1; tick();
    check("R4", 6, 16'h0000);
    checkAll();

    // Seeded random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 60 == 0) begin
        bip = NCH'($urandom); dif = NCH'($urandom);
        tog = NCH'($urandom); syn = NCH'($urandom);
      end
      clrN = ($urandom % 12) != 0;
      wrEn = ($urandom % 3) != 0;
      wrCh = AW'($urandom);
      wrSel = 1'($urandom);
      wrData = CW'($urandom);
      loadStb = ($urandom % 4) == 0;
      tsel = NCH'($urandom);
      #1;
      checkAll();
      modelStep();
      @(posedge clk);
      @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule